// File: doc/BRIEF.md
# Bus Agent Identity Configuration Unit

This block gives a symmetric bus agent its identity when reset ends and then places the agent's logical request lines onto its physical request pins. While the reset input is held active, the unit watches four active-low request pins. On the first clock edge at which reset is seen released, it latches the pin pattern and decodes the agent number from the pin that is pulled low. From then on, every logical request line is driven onto a pin chosen by rotating the line index down by the agent number, modulo the pin count. In a two-agent system, agent 0 uses pins 0 and 1 and agent 1 uses pins 3 and 0.

An agent strapped as the central agent drives pin 0 low for as long as reset is held. This pull-down is what tells the other agents their identity. A pattern that names no agent, or names more than one, raises a configuration-error flag and leaves the agent at number 0. The latched number holds until reset is asserted again.

Top module: `agent_id_cfg`

## Requirements
- R1: While rstN is low, and in the cycle in which its release is first sampled, cfgDone is 0 and no pin is enabled except pin 0. Pin 0 is enabled and driven low (pinOe = 4'b0001, pinOut = 4'b1110) only when centralMode is 1. Otherwise pinOe = 4'b0000 and pinOut = 4'b1111.
- R2: The pins are sampled at the first rising clock edge at which rstN is high. After that edge cfgDone is 1.
- R3: Only the pins in use are decoded, which are 0, 1 and 3. Pin 2 is ignored. Pin 0 low alone gives agentId 0 with cfgErr 0. Pin 3 low alone gives agentId 1 with cfgErr 0.
- R4: Any other pattern among pins 0, 1 and 3 (none low, pin 1 low, or two or more low) sets cfgErr to 1 and agentId to 0.
- R5: With agentId 0, request line 0 goes to pin 0 and line 1 goes to pin 1. pinOe = 4'b0011. A mapped pin is driven low when its line (active-high) is 1.
- R6: With agentId 1, request line 0 goes to pin 3 and line 1 goes to pin 0. pinOe = 4'b1001.
- R7: Pin 2 is never enabled. Every pin that is not enabled reads 1 on pinOut.
- R8: After configuration, agentId and cfgErr hold their values until rstN goes low again. Later changes on pinIn have no effect on them.
- R9: After configuration, centralMode has no effect on pinOe or pinOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, sampled synchronously |
| centralMode | input | 1 | Strap: this agent pulls pin 0 low during reset |
| pinIn | input | 4 | Levels seen on the active-low request pins |
| reqLine | input | 2 | Logical request lines, active-high |
| pinOut | output | 4 | Values driven on the request pins, active-low |
| pinOe | output | 4 | Output enable for each request pin |
| agentId | output | 1 | Latched agent number |
| cfgErr | output | 1 | Pattern at reset release was not legal |
| cfgDone | output | 1 | Identity has been latched |

## Verification
The bench sweeps all 16 pin patterns at reset release, each with the central strap both off and on. The two legal patterns show the decode of the single low pin, and patterns that differ only on pin 2 show that this pin is ignored. The remaining patterns (none low, pin 1 low, several low) separate the error path from a legal decode. For each resulting identity, all four request-line combinations are applied, which separates the two rotations and each line's pin. The strap is flipped and the pins are changed after configuration to show that the latched state holds.

// File: rtl/agent_cfg_pkg.sv
package agent_cfg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch decoded identity this edge
    logic clearId;   // reset held: clear identity
  } cfgStrobe_t;
endpackage

// File: rtl/agent_cfg_ctrl.sv
module agent_cfg_ctrl
  import agent_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  output cfgStrobe_t strobe,
  output logic       cfgDone
);
  logic inResetQ;
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inResetQ <= 1'b1;
      doneQ    <= 1'b0;
    end else begin
      inResetQ <= 1'b0;
      if (inResetQ) doneQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.capture = rstN && inResetQ;
    strobe.clearId = !rstN;
  end

  assign cfgDone = doneQ;

  // R2
  capture_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> cfgDone);

  // R2
  no_done_before_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDone && !strobe.capture) |=> !cfgDone);
endmodule

// File: rtl/agent_cfg_dp.sv
module agent_cfg_dp
  import agent_cfg_pkg::*;
#(
  parameter int PIN_W  = 4,
  parameter int AGENTS = 2,
  parameter int ID_W   = (AGENTS > 1) ? $clog2(AGENTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic              cfgDone,
  input  logic              centralMode,
  input  logic [PIN_W-1:0]  pinIn,
  input  logic [AGENTS-1:0] reqLine,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic [ID_W-1:0]   agentId,
  output logic              cfgErr
);
  // pins used by any agent: line i of agent a sits on pin (i - a) mod PIN_W
  function automatic logic [PIN_W-1:0] usedPins();
    logic [PIN_W-1:0] m;
    m = '0;
    for (int a = 0; a < AGENTS; a++)
      for (int i = 0; i < AGENTS; i++)
        m[(i + PIN_W - a) % PIN_W] = 1'b1;
    return m;
  endfunction

  localparam logic [PIN_W-1:0] USED = usedPins();

  logic [PIN_W-1:0] lowMask;
  logic [ID_W-1:0]  decId;
  logic             decHit;
  logic [ID_W-1:0]  idQ;
  logic             errQ;

  assign lowMask = ~pinIn & USED;

  always_comb begin
    decId  = '0;
    decHit = 1'b0;
    for (int a = 0; a < AGENTS; a++) begin
      if (lowMask == (PIN_W'(1) << ((PIN_W - a) % PIN_W))) begin
        decId  = ID_W'(a);
        decHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clearId) begin
      idQ  <= '0;
      errQ <= 1'b0;
    end else if (strobe.capture) begin
      idQ  <= decHit ? decId : '0;
      errQ <= !decHit;
    end
  end

  always_comb begin
    pinOe  = '0;
    pinOut = '1;
    if (!cfgDone) begin
      if (centralMode) begin
        pinOe[0]  = 1'b1;
        pinOut[0] = 1'b0;
      end
    end else begin
      for (int i = 0; i < AGENTS; i++) begin
        pinOe[(i + PIN_W - int'(idQ)) % PIN_W]  = 1'b1;
        pinOut[(i + PIN_W - int'(idQ)) % PIN_W] = ~reqLine[i];
      end
    end
  end

  assign agentId = idQ;
  assign cfgErr  = errQ;

  // R4
  err_forces_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (agentId == '0));

  // R8
  id_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDone && $past(cfgDone)) |-> ($stable(agentId) && $stable(cfgErr)));

  // R7
  unused_pin_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & ~USED) == '0) && ((pinOut | pinOe) == '1));

  // R1
  reset_drive_limit_chk: assert property (@(posedge clk)
    !cfgDone |-> ((pinOe & ~PIN_W'(1)) == '0));
endmodule

// File: rtl/agent_id_cfg.sv
module agent_id_cfg
  import agent_cfg_pkg::*;
#(
  parameter int PIN_W  = 4,
  parameter int AGENTS = 2,
  parameter int ID_W   = (AGENTS > 1) ? $clog2(AGENTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              centralMode,
  input  logic [PIN_W-1:0]  pinIn,
  input  logic [AGENTS-1:0] reqLine,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic [ID_W-1:0]   agentId,
  output logic              cfgErr,
  output logic              cfgDone
);
  cfgStrobe_t strobe;

  agent_cfg_ctrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgDone (cfgDone)
  );

  agent_cfg_dp #(.PIN_W(PIN_W), .AGENTS(AGENTS), .ID_W(ID_W)) dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgDone     (cfgDone),
    .centralMode (centralMode),
    .pinIn       (pinIn),
    .reqLine     (reqLine),
    .pinOut      (pinOut),
    .pinOe       (pinOe),
    .agentId     (agentId),
    .cfgErr      (cfgErr)
  );
endmodule

// File: tb/agent_id_cfg_test.sv
module agent_id_cfg_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       centralMode = 1'b0;
  logic [3:0] pinIn = 4'hF;
  logic [1:0] reqLine = 2'b00;
  logic [3:0] pinOut, pinOe;
  logic       agentId, cfgErr, cfgDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agent_id_cfg uut (
    .clk(clk), .rstN(rstN), .centralMode(centralMode), .pinIn(pinIn),
    .reqLine(reqLine), .pinOut(pinOut), .pinOe(pinOe), .agentId(agentId),
    .cfgErr(cfgErr), .cfgDone(cfgDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    for (int cm = 0; cm < 2; cm++) begin
      for (int pat = 0; pat < 16; pat++) begin
        logic [3:0] low;
        bit         l0, l1;
        int         expId, expErr, expOe;
        @(negedge clk);
        rstN = 1'b0;
        centralMode = cm[0];
        pinIn = pat[3:0];
        tick();
        tick();
        // R1: reset drive
        chk("R1 oe", pinOe, cm ? 4'b0001 : 4'b0000);
        chk("R1 out", pinOut, cm ? 4'b1110 : 4'b1111);
        chk("R1 done", cfgDone, 0);
        @(negedge clk);
        rstN = 1'b1;
        #1;
        // R1: release not yet sampled, still reset behaviour
        chk("R1 pre-edge oe", pinOe, cm ? 4'b0001 : 4'b0000);
        tick();
        // R2: captured at that edge
        chk("R2 done", cfgDone, 1);
        low = ~pat[3:0];
        l0 = low[0] && !low[1] && !low[3];
        l1 = low[3] && !low[0] && !low[1];
        expId  = l1 ? 1 : 0;
        expErr = (l0 || l1) ? 0 : 1;
        // R3 / R4
        chk(expErr ? "R4 id" : "R3 id", agentId, expId);
        chk(expErr ? "R4 err" : "R3 err", cfgErr, expErr);
        expOe = expId ? 4'b1001 : 4'b0011;
        for (int r = 0; r < 4; r++) begin
          int expOut;
          reqLine = r[1:0];
          #1;
          expOut = 4'hF;
          if (expId == 0) begin
            if (r[0]) expOut[0] = 1'b0;
            if (r[1]) expOut[1] = 1'b0;
          end else begin
            if (r[0]) expOut[3] = 1'b0;
            if (r[1]) expOut[0] = 1'b0;
          end
          // R5 / R6 mapping, R7 idle pins high
          chk(expId ? "R6 oe" : "R5 oe", pinOe, expOe);
          chk(expId ? "R6 out" : "R5 out", pinOut, expOut);
          chk("R7 pin2", pinOe[2], 0);
        end
        // R8: pins change, identity holds
        pinIn = ~pat[3:0];
        reqLine = 2'b11;
        tick();
        tick();
        chk("R8 id", agentId, expId);
        chk("R8 err", cfgErr, expErr);
        // R9: strap flip has no effect after configuration
        centralMode = ~cm[0];
        #1;
        chk("R9 oe", pinOe, expOe);
        chk("R9 out", pinOut, expId ? 4'b0110 : 4'b1100);
        reqLine = 2'b00;
      end
    end
    finished = 1;
    summary();
  end
endmodule